// File: doc/BRIEF.md
# Interval Timer with Match Compare and Optional Compare Buffer

This block is an up-counting interval timer for a small peripheral on a register bus. A counter advances by one on each single-cycle enable pulse taken from one of several prescaled tick inputs. When the count equals the active compare value, the next selected tick clears the counter to zero instead of advancing it, and the block emits a one-cycle interrupt pulse. With compare value N, interrupts therefore arrive every N+1 selected ticks.

Software sets up the block through one write port. A select code picks the target register. Code 0 is the mode register: bits [1:0] choose the tick source and bit 2 enables the compare buffer. Code 1 is the compare register. Code 2 is the run control, and only bit 0 of it is used. Code 3 is ignored. The mode register is frozen while the timer runs. When the compare buffer is enabled, a compare write made while running is held back and becomes active only at the next match, so the current interval is never cut short.

Top module: `match_interval_timer`

## Requirements
- R1: After reset the timer is stopped, the counter, compare value and buffer are zero, tick source 0 is selected, the buffer is off, and `irq` is low. Starting the timer without further setup then gives an interrupt on every tick of source 0.
- R2: While running, the counter advances only on a selected tick. With compare value N and the counter starting from zero, each interrupt comes exactly N+1 selected ticks after the previous one, for every N from 0 to 255.
- R3: A match raises `irq` for exactly one cycle, in the cycle that follows the matching tick's clock edge. At that same edge the counter returns to zero.
- R4: The mode field in bits [1:0] selects `tickIn[sel]`. Pulses on the other tick inputs neither advance the counter nor cause an interrupt.
- R5: Writing run = 0 stops the timer and clears the counter. A later start counts a full interval from zero.
- R6: A mode write made while the timer runs has no effect on the tick source or on the buffer enable.
- R7: With the buffer enabled and the timer running, a compare write only loads the buffer. The old value stays in use until the next match, and the buffered value is used from that match on.
- R8: With the buffer enabled and the timer stopped, a compare write updates the buffer and the active value together.
- R9: With the buffer disabled, a compare write takes effect at once, even while running. If the new value is below the current count, the counter runs up to 255, wraps to 0 and climbs to the new value before the next match.
- R10: If a buffered compare write arrives in the same cycle as a match, the match activates the value held in the buffer before the write, and the newly written value becomes active at the following match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 mode, 1 compare, 2 run, 3 ignored |
| wrData | input | 8 | Write data |
| tickIn | input | 4 | Single-cycle count enables, one per source |
| irq | output | 1 | One-cycle interrupt pulse on match |

## Verification
The only output is the interrupt, so any wrong count, stale compare value or wrongly latched mode shows up as an interrupt that arrives early, late, or on the wrong tick source. A counter that is not cleared on stop, or a buffer that loads at the wrong moment, lengthens or shortens the very next interval by a predictable number of ticks. That error is seen at most one wrap of the counter later, which is 256 ticks. The bench therefore counts selected ticks between interrupts and compares them with N+1, or with the wrap-around length where the requirement calls for it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CMP  = 2'd1;
  localparam logic [1:0] SEL_RUN  = 2'd2;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic cntClear;    // counter to zero (stop or match)
    logic cntInc;      // counter advances
    logic matchEvt;    // match consumed a tick: raise irq
    logic actFromBuf;  // active compare takes buffered value
    logic actFromWr;   // active compare takes write data
    logic bufFromWr;   // buffer takes write data
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = $clog2(NUM_SRC),
  localparam int CFG_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [NUM_SRC-1:0] tickIn,
  input  logic             matchHit,
  output logic             running,
  output logic [SEL_W-1:0] srcSel,
  output logic             bufEn,
  output tmrStrobe_t       strobe
);
  logic wrMode, wrCmp, wrRun, stopReq, tickSel, advance, matchEvt;

  always_comb begin
    wrMode   = wrEn && (wrSel == SEL_MODE);
    wrCmp    = wrEn && (wrSel == SEL_CMP);
    wrRun    = wrEn && (wrSel == SEL_RUN);
    stopReq  = wrRun && !cfgData[0];
    tickSel  = tickIn[srcSel];
    advance  = running && tickSel && !stopReq;
    matchEvt = advance && matchHit;

    strobe.cntClear   = stopReq || matchEvt;
    strobe.cntInc     = advance && !matchHit;
    strobe.matchEvt   = matchEvt;
    strobe.actFromBuf = matchEvt && bufEn;
    strobe.bufFromWr  = wrCmp;
    strobe.actFromWr  = wrCmp && (!running || !bufEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      srcSel  <= '0;
      bufEn   <= 1'b0;
    end else begin
      if (wrRun) running <= cfgData[0];
      if (wrMode && !running) {bufEn, srcSel} <= cfgData;
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] wrData,
  input  tmrStrobe_t       strobe,
  output logic             matchHit,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] actVal,
  output logic             irq
);
  logic [CNT_W-1:0] bufVal;

  assign matchHit = (cntVal == actVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
      actVal <= '0;
      bufVal <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= strobe.matchEvt;
      if (strobe.cntClear)    cntVal <= '0;
      else if (strobe.cntInc) cntVal <= cntVal + 1'b1;
      if (strobe.bufFromWr) bufVal <= wrData;
      // actFromWr and actFromBuf are mutually exclusive by construction of control
      if (strobe.actFromWr)       actVal <= wrData;
      else if (strobe.actFromBuf) actVal <= bufVal;
    end
  end
endmodule

// File: rtl/match_interval_timer.sv
module match_interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4,
  localparam int SEL_W = $clog2(NUM_SRC),
  localparam int CFG_W = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic               irq
);
  tmrStrobe_t       strobe;
  logic             matchHit, running, bufEn;
  logic [SEL_W-1:0] srcSel;
  logic [CNT_W-1:0] cntVal, actVal;

  timer_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .cfgData(wrData[CFG_W-1:0]), .tickIn(tickIn), .matchHit(matchHit),
    .running(running), .srcSel(srcSel), .bufEn(bufEn), .strobe(strobe)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .matchHit(matchHit), .cntVal(cntVal), .actVal(actVal), .irq(irq)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic             irq,
  input logic             running,
  input logic             bufEn,
  input logic [SEL_W-1:0] srcSel,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] actVal
);
  // R1: a stopped timer always holds a zero count
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> cntVal == '0);

  // R2: the counter only holds, steps by one, or returns to zero
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntVal == $past(cntVal) || cntVal == CNT_W'($past(cntVal) + 1'b1) || cntVal == '0));

  // R3: interrupt coincides with a cleared counter
  a_r3_irq_zero: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> cntVal == '0);

  // R5: a stop write clears the counter and halts the timer
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_RUN && !wrData[0]) |=> (cntVal == '0 && !running));

  // R6: mode is frozen while running
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable({bufEn, srcSel}));

  // R7: buffered active value only changes at a match
  a_r7_active_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (running && bufEn) |=> ($stable(actVal) || irq));
endmodule

bind match_interval_timer timer_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .irq(irq), .running(running), .bufEn(bufEn), .srcSel(srcSel),
  .cntVal(cntVal), .actVal(actVal)
);

// File: tb/match_interval_timer_bench.sv
`timescale 1ns/1ps
module match_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [3:0] tickIn = 4'd0;
  logic       irq;
  int total = 0;
  int fails = 0;

  localparam logic [1:0] MODE = 2'd0, CMP = 2'd1, RUN = 2'd2;

  always #2.5 clk = ~clk;

  match_interval_timer u_match_interval_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .tickIn(tickIn), .irq(irq)
  );

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input int idx, output logic got);
    tickIn = 4'b1 << idx;
    @(negedge clk);
    got = irq;
    tickIn = 4'd0;
  endtask

  task automatic pulseWr(input int idx, input logic [7:0] d, output logic got);
    tickIn = 4'b1 << idx; wrEn = 1'b1; wrSel = CMP; wrData = d;
    @(negedge clk);
    got = irq;
    tickIn = 4'd0; wrEn = 1'b0;
  endtask

  task automatic measure(input int idx, output int n);
    logic got;
    n = 0; got = 1'b0;
    while (!got && n < 600) begin
      pulse(idx, got);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic got;
    int n, hits;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(irq, 0, "R1 irq low after reset");
    wr(RUN, 8'd1);
    for (int i = 0; i < 3; i++) begin
      pulse(0, got);
      check(got, 1, "R1 default compare 0 on source 0");
    end
    wr(RUN, 8'd0);

    // R2 and R3: full compare sweep on source 0, buffer off
    for (int c = 0; c < 256; c++) begin
      wr(CMP, 8'(c));
      wr(RUN, 8'd1);
      measure(0, n);
      check(n, c + 1, "R2 interval first");
      @(negedge clk);
      check(irq, 0, "R3 single-cycle irq");
      measure(0, n);
      check(n, c + 1, "R2 interval second");
      wr(RUN, 8'd0);
    end

    // R4: each source selected in turn, others ignored
    for (int s = 0; s < 4; s++) begin
      wr(MODE, 8'(s));
      wr(CMP, 8'd3);
      wr(RUN, 8'd1);
      hits = 0;
      for (int o = 0; o < 4; o++) begin
        if (o != s) begin
          for (int k = 0; k < 5; k++) begin
            pulse(o, got);
            hits += int'(got);
          end
        end
      end
      check(hits, 0, "R4 other sources ignored");
      measure(s, n);
      check(n, 4, "R4 selected source interval");
      wr(RUN, 8'd0);
    end

    // R6: mode write while running ignored
    wr(MODE, 8'd1);
    wr(CMP, 8'd4);
    wr(RUN, 8'd1);
    wr(MODE, 8'h06);
    hits = 0;
    for (int k = 0; k < 8; k++) begin
      pulse(2, got);
      hits += int'(got);
    end
    check(hits, 0, "R6 source kept while running");
    measure(1, n);
    check(n, 5, "R6 interval on kept source");
    wr(CMP, 8'd2);
    measure(1, n);
    check(n, 3, "R6 buffer enable kept off");
    wr(RUN, 8'd0);

    // R5: stop clears the counter
    wr(MODE, 8'd0);
    wr(CMP, 8'd5);
    wr(RUN, 8'd1);
    for (int k = 0; k < 3; k++) pulse(0, got);
    wr(RUN, 8'd0);
    wr(RUN, 8'd1);
    measure(0, n);
    check(n, 6, "R5 full interval after restart");
    wr(RUN, 8'd0);

    // R9: unbuffered write, below and above current count
    wr(CMP, 8'd10);
    wr(RUN, 8'd1);
    for (int k = 0; k < 6; k++) pulse(0, got);
    wr(CMP, 8'd3);
    measure(0, n);
    check(n, 254, "R9 wrap after lower compare");
    measure(0, n);
    check(n, 4, "R9 new compare in use");
    wr(CMP, 8'd10);
    measure(0, n);
    check(n, 11, "R9 immediate compare raise");
    wr(RUN, 8'd0);

    // R8: buffered, write while stopped is immediate
    wr(MODE, 8'h04);
    wr(CMP, 8'd4);
    wr(RUN, 8'd1);
    measure(0, n);
    check(n, 5, "R8 stopped write active at once");

    // R7: buffered write while running waits for match
    for (int k = 0; k < 2; k++) pulse(0, got);
    wr(CMP, 8'd1);
    measure(0, n);
    check(n, 3, "R7 old compare until match");
    measure(0, n);
    check(n, 2, "R7 buffered compare after match");
    wr(RUN, 8'd0);

    // R10: buffered write colliding with match
    wr(CMP, 8'd2);
    wr(RUN, 8'd1);
    pulse(0, got);
    wr(CMP, 8'd5);
    pulse(0, got);
    pulseWr(0, 8'd7, got);
    check(got, 1, "R10 match in collision cycle");
    measure(0, n);
    check(n, 6, "R10 earlier buffer value activated");
    measure(0, n);
    check(n, 8, "R10 colliding write kept for next match");
    wr(RUN, 8'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule